// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block collects stores aimed at uncached, write-combining memory and packs them into a few line-sized buffers. Each buffer holds one line image together with a per-byte valid mask. A store to a line that is already held is merged into that buffer's image. A store to a new line takes a free buffer. Nothing reaches memory while buffers remain free.

A line leaves the block as a single burst on a memory write port and does not pass through any cache. Two events cause this. The first is a store that needs a buffer when none is free: the line allocated longest ago is evicted. The second is a fence request: every held line is written out, and the fence is reported complete only once all of them have been acknowledged. Buffered data is invisible outside the core until it is written. The order in which lines leave need not match the order of the stores that built them.

Top module: `wc_store_buffer`

## Requirements
- R1: After reset no line is held, `memValid` and `fenceDone` are low, and `stReady` is high while `fenceReq` is low.
- R2: A store to a line not held, while a buffer is free, is accepted in the cycle it is presented. It takes a free buffer and starts no memory write.
- R3: The store address splits into line tag `stAddr[ADDR_W-1:4]` and word slot `stAddr[3:2]`. With the defaults, lane k of `stData`/`stBe` maps to line byte slot*4+k, and line byte j appears on `memData[8j+7:8j]` and `memBe[j]`. A later store overwrites only its enabled bytes and sets their enable bits. Bytes never written read as zero with a clear enable.
- R4: A store that misses every held line while all buffers are full is stalled (`stReady` low). The line allocated earliest is written out, whether or not it was hit since. The stalled store is then accepted into the freed buffer.
- R5: A line write holds `memValid` with a stable, line-aligned address, data and byte enables until `memAck`. The buffer is freed by that acknowledge.
- R6: A fence request writes out every held line. `fenceDone` pulses for one cycle only once no line is held. With nothing held, the pulse comes in the cycle after the request.
- R7: No store is accepted while a line write is outstanding or a fence is pending, and a fence request wins over a store presented in the same cycle.
- R8: At most one buffer holds any given line tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store presented |
| stReady | output | 1 | Store accepted this cycle when high with stValid |
| stAddr | input | ADDR_W | Store byte address |
| stData | input | WORD_BYTES*8 | Store data word |
| stBe | input | WORD_BYTES | Store byte enables |
| fenceReq | input | 1 | One-cycle fence request |
| fenceDone | output | 1 | One-cycle pulse: all lines written |
| memValid | output | 1 | Line write pending |
| memAddr | output | ADDR_W | Line-aligned write address |
| memData | output | LINE_BYTES*8 | Line image |
| memBe | output | LINE_BYTES | Per-byte write enables |
| memAck | input | 1 | Memory accepts the pending write |

## Verification
Store acceptance is combinational. The bench samples `stReady` one time unit after driving a store at the falling edge and commits the store to its model on the next rising edge. A line write appears on the memory port in the cycle after the stalling store or the fence request is sampled. It is compared against the model when the bench raises `memAck`, after a random wait of zero to two cycles, and the model drops the line at that point. `fenceDone` is expected at the falling edge one cycle after the last acknowledge, or one cycle after the request when nothing is held, and is checked to be low again one cycle later.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_EVICT = 2'd1,
    S_FLUSH = 2'd2
  } wcbState_e;

  // strobes from control to the line storage
  typedef struct packed {
    logic allocEn;
    logic mergeEn;
    logic freeEn;
  } wcbCtl_t;

endpackage

// File: rtl/wcb_lines.sv
module wcb_lines
  import wcb_pkg::*;
#(
  parameter int NUM_BUF    = 4,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wcbCtl_t                   ctl,
  input  logic [$clog2(NUM_BUF)-1:0] tgtIdx,
  input  logic [$clog2(NUM_BUF)-1:0] rdIdx,
  input  logic [ADDR_W-1:0]         stAddr,
  input  logic [WORD_BYTES*8-1:0]   stData,
  input  logic [WORD_BYTES-1:0]     stBe,
  output logic [NUM_BUF-1:0]        hitVec,
  output logic [NUM_BUF-1:0]        validVec,
  output logic [$clog2(NUM_BUF)-1:0] oldestIdx,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [LINE_BYTES*8-1:0]   memData,
  output logic [LINE_BYTES-1:0]     memBe
);

  localparam int IDX_W   = $clog2(NUM_BUF);
  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int WORD_OFF = $clog2(WORD_BYTES);
  localparam int SLOT_W  = LINE_OFF - WORD_OFF;
  localparam int TAG_W   = ADDR_W - LINE_OFF;
  localparam logic [IDX_W-1:0] MAX_RANK = IDX_W'(NUM_BUF - 1);

  logic [TAG_W-1:0]        lineTag  [NUM_BUF];
  logic [LINE_BYTES*8-1:0] lineData [NUM_BUF];
  logic [LINE_BYTES-1:0]   lineBe   [NUM_BUF];
  logic [IDX_W-1:0]        lineRank [NUM_BUF];
  logic [NUM_BUF-1:0]      lineValid;

  logic [TAG_W-1:0]        stTag;
  logic [SLOT_W-1:0]       stSlot;
  logic [LINE_BYTES-1:0]   byteSel;
  logic [LINE_BYTES*8-1:0] byteVal;

  assign stTag  = stAddr[ADDR_W-1:LINE_OFF];
  assign stSlot = stAddr[LINE_OFF-1:WORD_OFF];

  // spread the store word over the line image
  always_comb begin
    for (int j = 0; j < LINE_BYTES; j++) begin
      byteSel[j] = (SLOT_W'(j / WORD_BYTES) == stSlot) && stBe[j % WORD_BYTES];
      byteVal[j*8 +: 8] = stData[(j % WORD_BYTES)*8 +: 8];
    end
  end

  generate
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_hit
      assign hitVec[i] = lineValid[i] && (lineTag[i] == stTag);
    end
  endgenerate

  assign validVec = lineValid;

  // rank 0 = newest allocation; rank NUM_BUF-1 = oldest when full
  always_comb begin
    oldestIdx = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (lineValid[i] && lineRank[i] == MAX_RANK) oldestIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
      for (int i = 0; i < NUM_BUF; i++) begin
        lineTag[i]  <= '0;
        lineData[i] <= '0;
        lineBe[i]   <= '0;
        lineRank[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (ctl.freeEn && rdIdx == IDX_W'(i)) lineValid[i] <= 1'b0;
        if (ctl.allocEn) begin
          if (tgtIdx == IDX_W'(i)) begin
            lineValid[i] <= 1'b1;
            lineTag[i]   <= stTag;
            lineRank[i]  <= '0;
            for (int j = 0; j < LINE_BYTES; j++) begin
              lineData[i][j*8 +: 8] <= byteSel[j] ? byteVal[j*8 +: 8] : 8'h00;
              lineBe[i][j]          <= byteSel[j];
            end
          end else if (lineValid[i]) begin
            lineRank[i] <= lineRank[i] + 1'b1;
          end
        end else if (ctl.mergeEn && tgtIdx == IDX_W'(i)) begin
          for (int j = 0; j < LINE_BYTES; j++) begin
            if (byteSel[j]) begin
              lineData[i][j*8 +: 8] <= byteVal[j*8 +: 8];
              lineBe[i][j]          <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign memAddr = {lineTag[rdIdx], {LINE_OFF{1'b0}}};
  assign memData = lineData[rdIdx];
  assign memBe   = lineBe[rdIdx];

  // R8: a tag lives in one buffer at most
  a_r8_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R2: an allocated buffer is held in the next cycle
  a_r2_alloc_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.allocEn |=> lineValid[$past(tgtIdx)]);

  // R3: a merge never drops a byte enable already set
  a_r3_merge_keeps: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mergeEn |=> ((lineBe[$past(tgtIdx)] & $past(lineBe[tgtIdx])) == $past(lineBe[tgtIdx])));

endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
  import wcb_pkg::*;
#(
  parameter int NUM_BUF = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       stValid,
  output logic                       stReady,
  input  logic                       fenceReq,
  output logic                       fenceDone,
  output logic                       memValid,
  input  logic                       memAck,
  input  logic [NUM_BUF-1:0]         hitVec,
  input  logic [NUM_BUF-1:0]         validVec,
  input  logic [$clog2(NUM_BUF)-1:0] oldestIdx,
  output wcbCtl_t                    ctl,
  output logic [$clog2(NUM_BUF)-1:0] tgtIdx,
  output logic [$clog2(NUM_BUF)-1:0] rdIdx
);

  localparam int IDX_W = $clog2(NUM_BUF);

  wcbState_e         state, stateNext;
  logic              fencePend, fencePendNext;
  logic [IDX_W-1:0]  victimIdx, victimNext;
  logic [IDX_W-1:0]  hitIdx, freeIdx, lowValidIdx;
  logic              anyHit, allFull, anyValid;

  assign anyHit   = |hitVec;
  assign allFull  = &validVec;
  assign anyValid = |validVec;

  always_comb begin
    hitIdx      = '0;
    freeIdx     = '0;
    lowValidIdx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (hitVec[i])    hitIdx      = IDX_W'(i);
      if (!validVec[i]) freeIdx     = IDX_W'(i);
      if (validVec[i])  lowValidIdx = IDX_W'(i);
    end
  end

  always_comb begin
    stateNext     = state;
    fencePendNext = fencePend;
    victimNext    = victimIdx;
    stReady       = 1'b0;
    fenceDone     = 1'b0;
    memValid      = 1'b0;
    ctl           = '0;
    tgtIdx        = anyHit ? hitIdx : freeIdx;
    rdIdx         = victimIdx;
    unique case (state)
      S_IDLE: begin
        stReady     = !fenceReq && !fencePend && (anyHit || !allFull);
        ctl.mergeEn = stValid && stReady && anyHit;
        ctl.allocEn = stValid && stReady && !anyHit;
        if (fenceReq || fencePend) begin
          stateNext     = S_FLUSH;
          fencePendNext = 1'b0;
        end else if (stValid && !anyHit && allFull) begin
          stateNext  = S_EVICT;
          victimNext = oldestIdx;
        end
      end
      S_EVICT: begin
        memValid = 1'b1;
        if (fenceReq) fencePendNext = 1'b1;
        if (memAck) begin
          ctl.freeEn = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      S_FLUSH: begin
        rdIdx = lowValidIdx;
        if (anyValid) begin
          memValid   = 1'b1;
          ctl.freeEn = memAck;
        end else begin
          fenceDone = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      fencePend <= 1'b0;
      victimIdx <= '0;
    end else begin
      state     <= stateNext;
      fencePend <= fencePendNext;
      victimIdx <= victimNext;
    end
  end

  // R5: an unacknowledged write keeps its line selected
  a_r5_write_held: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memAck) |=> (memValid && $stable(rdIdx)));

  // R6: completion only once nothing is held
  a_r6_done_empty: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |-> (validVec == '0));

  // R7: stores never enter while a line is on the memory port
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady) |-> !memValid);

  // R4: eviction happens only with every buffer in use
  a_r4_evict_full: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVICT) |-> allFull);

endmodule

// File: rtl/wc_store_buffer.sv
module wc_store_buffer
  import wcb_pkg::*;
#(
  parameter int NUM_BUF    = 4,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stValid,
  output logic                    stReady,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [WORD_BYTES*8-1:0] stData,
  input  logic [WORD_BYTES-1:0]   stBe,
  input  logic                    fenceReq,
  output logic                    fenceDone,
  output logic                    memValid,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0] memData,
  output logic [LINE_BYTES-1:0]   memBe,
  input  logic                    memAck
);

  localparam int IDX_W = $clog2(NUM_BUF);

  wcbCtl_t            ctl;
  logic [IDX_W-1:0]   tgtIdx, rdIdx, oldestIdx;
  logic [NUM_BUF-1:0] hitVec, validVec;

  wcb_ctrl #(.NUM_BUF(NUM_BUF)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stReady(stReady),
    .fenceReq(fenceReq), .fenceDone(fenceDone),
    .memValid(memValid), .memAck(memAck),
    .hitVec(hitVec), .validVec(validVec), .oldestIdx(oldestIdx),
    .ctl(ctl), .tgtIdx(tgtIdx), .rdIdx(rdIdx)
  );

  wcb_lines #(
    .NUM_BUF(NUM_BUF), .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)
  ) u_lines (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .tgtIdx(tgtIdx), .rdIdx(rdIdx),
    .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .hitVec(hitVec), .validVec(validVec), .oldestIdx(oldestIdx),
    .memAddr(memAddr), .memData(memData), .memBe(memBe)
  );

endmodule

// File: tb/wc_store_buffer_tb.sv
module wc_store_buffer_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stValid = 1'b0;
  logic         stReady;
  logic [31:0]  stAddr = '0;
  logic [31:0]  stData = '0;
  logic [3:0]   stBe = '0;
  logic         fenceReq = 1'b0;
  logic         fenceDone;
  logic         memValid;
  logic [31:0]  memAddr;
  logic [127:0] memData;
  logic [15:0]  memBe;
  logic         memAck = 1'b0;

  wc_store_buffer u_dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .fenceReq(fenceReq), .fenceDone(fenceDone),
    .memValid(memValid), .memAddr(memAddr), .memData(memData),
    .memBe(memBe), .memAck(memAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int numChecks = 0;
  int numFail = 0;
  bit reported = 0;
  bit fenceMode = 0;

  // model, index 0 = earliest allocated
  logic [27:0]  mTag  [4];
  logic [127:0] mData [4];
  logic [15:0]  mBe   [4];
  int mCnt = 0;

  task automatic check(input bit ok, input string msg);
    numChecks++;
    if (!ok) begin
      numFail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFail);
    end
  endtask

  function automatic int findTag(input logic [27:0] t);
    for (int i = 0; i < mCnt; i++) if (mTag[i] == t) return i;
    return -1;
  endfunction

  task automatic modelStore(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    int i;
    i = findTag(a[31:4]);
    if (i < 0) begin
      i = mCnt;
      mTag[i] = a[31:4]; mData[i] = '0; mBe[i] = '0;
      mCnt++;
    end
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        mData[i][(a[3:2]*4 + k)*8 +: 8] = d[k*8 +: 8];
        mBe[i][a[3:2]*4 + k] = 1'b1;
      end
    end
  endtask

  task automatic modelRemove(input int i);
    for (int k = i; k < mCnt - 1; k++) begin
      mTag[k] = mTag[k+1]; mData[k] = mData[k+1]; mBe[k] = mBe[k+1];
    end
    mCnt--;
  endtask

  // memory responder: checks each line when acknowledging it
  int waitLeft = 0;
  bit busy = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memAck) begin
        memAck <= 1'b0;
        busy = 0;
      end else if (memValid) begin
        if (!busy) begin
          busy = 1;
          waitLeft = $urandom % 3;
          // R2: no write while a buffer is free outside a fence
          check(fenceMode || mCnt == 4,
                $sformatf("R2 write with free buffers: cnt=%0d exp=4", mCnt));
        end
        if (waitLeft == 0) begin
          int idx;
          idx = fenceMode ? findTag(memAddr[31:4]) : 0;
          if (idx < 0) begin
            check(0, $sformatf("R6 flushed line addr=%h not held, exp a held tag", memAddr));
          end else begin
            check(memAddr[3:0] == 4'h0 && memAddr[31:4] == mTag[idx],
                  $sformatf("%s addr act=%h exp=%h", fenceMode ? "R6" : "R4",
                            memAddr, {mTag[idx], 4'h0}));
            check(memData == mData[idx] && memBe == mBe[idx],
                  $sformatf("R3 R5 line act=%h/%h exp=%h/%h", memData, memBe,
                            mData[idx], mBe[idx]));
            modelRemove(idx);
          end
          memAck <= 1'b1;
        end else begin
          waitLeft--;
        end
      end
    end
  end

  task automatic doStore(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    bit expReady;
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; stBe = be;
    #1;
    expReady = (findTag(a[31:4]) >= 0) || (mCnt < 4);
    check(stReady == expReady,
          $sformatf("R2 R4 stReady act=%0b exp=%0b", stReady, expReady));
    while (!stReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    modelStore(a, d, be);
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic waitDone(input int firstWait);
    int cnt = 0;
    while (!fenceDone && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check(fenceDone == 1'b1, $sformatf("R6 fenceDone act=%0b exp=1", fenceDone));
    if (firstWait >= 0)
      check(cnt == firstWait, $sformatf("R6 done latency act=%0d exp=%0d", cnt, firstWait));
    check(mCnt == 0, $sformatf("R6 lines left act=%0d exp=0", mCnt));
    @(negedge clk);
    check(fenceDone == 1'b0, $sformatf("R6 done pulse width act=%0b exp=0", fenceDone));
    fenceMode = 0;
  endtask

  task automatic doFence(input int firstWait);
    @(negedge clk);
    fenceMode = 1;
    fenceReq = 1'b1;
    @(negedge clk);
    fenceReq = 1'b0;
    waitDone(firstWait);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    numFail++;
    $display("FAIL watchdog expired act=timeout exp=completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1
    check(stReady == 1'b1, $sformatf("R1 stReady act=%0b exp=1", stReady));
    check(memValid == 1'b0, $sformatf("R1 memValid act=%0b exp=0", memValid));
    check(fenceDone == 1'b0, $sformatf("R1 fenceDone act=%0b exp=0", fenceDone));

    // R6: empty fence completes in the cycle after the request
    doFence(0);

    // R3: merging within one line
    doStore(32'h0000_1000, 32'h1122_3344, 4'b1111);
    doStore(32'h0000_1000, 32'hAABB_CCDD, 4'b0011);
    doStore(32'h0000_100C, 32'h5500_0000, 4'b1000);
    doStore(32'h0000_1204, 32'h0000_0077, 4'b0001);
    repeat (3) @(negedge clk);
    check(memValid == 1'b0, $sformatf("R2 idle write act=%0b exp=0", memValid));
    doFence(-1);

    // R4: earliest allocation leaves, even though it was hit again
    doStore(32'h0000_2010, 32'h0101_0101, 4'b1111);
    doStore(32'h0000_2020, 32'h0202_0202, 4'b1111);
    doStore(32'h0000_2030, 32'h0303_0303, 4'b1111);
    doStore(32'h0000_2040, 32'h0404_0404, 4'b1111);
    doStore(32'h0000_2018, 32'h0909_0909, 4'b0101);
    doStore(32'h0000_2050, 32'h0505_0505, 4'b1111);
    check(findTag(28'h0000_201) < 0, "R4 earliest line still held act=held exp=evicted");

    // R7: fence wins over a simultaneous store
    @(negedge clk);
    fenceMode = 1;
    fenceReq = 1'b1;
    stValid = 1'b1; stAddr = 32'h0000_2024; stData = 32'hDEAD_BEEF; stBe = 4'b1111;
    #1;
    check(stReady == 1'b0, $sformatf("R7 stReady with fence act=%0b exp=0", stReady));
    @(negedge clk);
    fenceReq = 1'b0;
    #1;
    while (!stReady) begin
      @(negedge clk);
      #1;
    end
    check(mCnt == 0, $sformatf("R7 store entered before flush, lines act=%0d exp=0", mCnt));
    fenceMode = 0;
    @(posedge clk);
    modelStore(stAddr, stData, stBe);
    @(negedge clk);
    stValid = 1'b0;
    doFence(-1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 10 == 0) begin
        doFence(-1);
      end else begin
        logic [31:0] a;
        logic [3:0]  be;
        a = {24'h000030, 4'(($urandom % 6)), 4'h0} | {28'h0, 2'($urandom), 2'b00};
        be = 4'($urandom);
        if (be == 4'h0) be = 4'h1;
        doStore(a, $urandom, be);
      end
    end
    doFence(-1);

    report();
    $finish;
  end

endmodule